// File: doc/BRIEF.md
# Two-Deep Controller Command Queue

This block is the command register of a bus-controller core. A host writes 8-bit command bytes through a byte-wide write strobe. Each byte is decoded into an operation code, a DMA request flag (bit 7) and a command class taken from bits 6..4. The byte is then checked against the controller's current connection mode. Legal commands enter a queue that holds two entries. The execution engine sees the oldest entry and takes it with a valid/accept handshake.

A byte that is illegal for the current mode is not queued and sets a sticky illegal-command flag. A byte that names an undefined operation is treated the same way, and so is a legal byte written while both entries are occupied. The flag stays set until the host acknowledges the interrupt. The reset-chip command is handled inside the block and is never queued. It empties the queue, clears the flag and emits a one-cycle reset pulse for the rest of the controller.

Top module: `ctrl_cmd_queue`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `cmd_valid`, `illegal_cmd` and `chip_reset` are 0.
- R2: The head entry presents `cmd_op` = byte[6:0] and `cmd_dma` = byte[7]. It also presents `cmd_class`, encoded as 0 for miscellaneous (bits 6..4 all clear), 1 for disconnected (bit 6), 2 for target (bit 5) and 3 for initiator (bit 4). All of these appear on the cycle after the write edge when the queue was empty.
- R3: A second legal write is queued behind the first. The head entry does not change while it is not accepted.
- R4: A high `cmd_accept` while `cmd_valid` is high removes the head entry at that edge, and the queued entry becomes the head at the same edge. A high `cmd_accept` on an empty queue has no effect.
- R5: `mode` is encoded as 0 disconnected, 1 target, 2 initiator and 3 idle. Miscellaneous commands are legal in every mode. Any other class is legal only in its matching mode. An illegal byte is not queued and sets `illegal_cmd` on the next cycle.
- R6: Only the following operations are defined, and any other byte is illegal as in R5:
  - miscellaneous 0x00 to 0x04;
  - disconnected 0x40 to 0x46;
  - target 0x20 to 0x25 and 0x27 to 0x2B;
  - initiator 0x10, 0x11, 0x12, 0x18, 0x1A and 0x1B.
  A byte with more than one of bits 6..4 set is also illegal. Bit 7 does not affect whether a byte is legal.
- R7: A legal write while both entries are held and no accept occurs is dropped and sets `illegal_cmd`. Both stored entries are kept. A write in the same cycle as an accept of a full queue is queued.
- R8: A byte whose low seven bits are 0x02 (reset chip) is legal in every mode, with or without bit 7. It is not queued. On the next cycle the queue is empty, `illegal_cmd` is 0 and `chip_reset` is 1 for exactly one cycle. It takes precedence over a simultaneous accept.
- R9: `illegal_cmd` stays set until a cycle with `irq_ack` high clears it. A new illegal event in the same cycle as `irq_ack` leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Connection mode: 0 disconnected, 1 target, 2 initiator, 3 idle |
| wr_en | input | 1 | Host command-byte write strobe |
| wr_data | input | 8 | Command byte |
| cmd_accept | input | 1 | Execution engine takes the head entry |
| irq_ack | input | 1 | Host acknowledge that clears the illegal-command flag |
| cmd_valid | output | 1 | A head entry is present |
| cmd_op | output | 7 | Operation code of the head entry |
| cmd_dma | output | 1 | DMA request of the head entry |
| cmd_class | output | 2 | Decoded class of the head entry |
| illegal_cmd | output | 1 | Sticky illegal-command flag |
| chip_reset | output | 1 | One-cycle pulse after a reset-chip command |

## Verification
The properties assume that `mode` is stable during the cycle in which a byte is written. They also assume that the engine raises `cmd_accept` only by its own choice: a high accept on an empty queue is allowed and is expected to do nothing. The stimulus changes every input only between clock edges and holds `mode` constant around each write. It drives accept and acknowledge both alone and together with writes, so the cases where events coincide are exercised: accept with overflow, accept with reset-chip, and acknowledge with a new illegal event.

// File: rtl/cq_pkg.sv
package cq_pkg;

    localparam int CMD_W = 8;
    localparam int OP_W  = CMD_W - 1;

    typedef enum logic [1:0] {
        CLS_MISC = 2'd0,
        CLS_DISC = 2'd1,
        CLS_TARG = 2'd2,
        CLS_INIT = 2'd3
    } cmd_class_e;

    typedef enum logic [1:0] {
        MODE_DISC = 2'd0,
        MODE_TARG = 2'd1,
        MODE_INIT = 2'd2,
        MODE_IDLE = 2'd3
    } op_mode_e;

    typedef struct packed {
        logic            dma;
        cmd_class_e      cls;
        logic [OP_W-1:0] op;
    } cmd_entry_t;

    localparam int ENTRY_W = $bits(cmd_entry_t);

    localparam logic [OP_W-1:0] OP_CHIP_RESET = 7'h02;

    // Class bits sit in op[6:4]; more than one set is not a class.
    function automatic logic class_ambiguous(logic [OP_W-1:0] op);
        return $countones(op[6:4]) > 1;
    endfunction

    function automatic cmd_class_e class_of(logic [OP_W-1:0] op);
        cmd_class_e c;
        case (op[6:4])
            3'b100:  c = CLS_DISC;
            3'b010:  c = CLS_TARG;
            3'b001:  c = CLS_INIT;
            default: c = CLS_MISC;
        endcase
        return c;
    endfunction

    function automatic logic op_defined(logic [OP_W-1:0] op);
        logic d;
        case (op[6:4])
            3'b000:  d = (op[3:0] <= 4'h4);
            3'b100:  d = (op[3:0] <= 4'h6);
            3'b010:  d = (op[3:0] <= 4'hB) && (op[3:0] != 4'h6);
            3'b001:  d = (op[3:0] <= 4'h2) || (op[3:0] == 4'h8) ||
                         (op[3:0] == 4'hA) || (op[3:0] == 4'hB);
            default: d = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic class_fits_mode(cmd_class_e c, op_mode_e m);
        logic ok;
        case (c)
            CLS_MISC: ok = 1'b1;
            CLS_DISC: ok = (m == MODE_DISC);
            CLS_TARG: ok = (m == MODE_TARG);
            CLS_INIT: ok = (m == MODE_INIT);
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/cq_decode.sv
module cq_decode
    import cq_pkg::*;
(
    input  logic [CMD_W-1:0] byte_in,
    input  op_mode_e         mode,
    output cmd_entry_t       entry,
    output logic             legal,
    output logic             is_chip_reset
);
    logic [OP_W-1:0] op;
    cmd_class_e      cls;

    always_comb begin
        op            = byte_in[OP_W-1:0];
        cls           = class_of(op);
        entry.dma     = byte_in[CMD_W-1];
        entry.cls     = cls;
        entry.op      = op;
        legal         = op_defined(op) && !class_ambiguous(op) &&
                        class_fits_mode(cls, mode);
        is_chip_reset = (op == OP_CHIP_RESET);
    end

    // R8: a reset-chip byte is accepted in every mode
    always_comb begin
        if (is_chip_reset) begin
            chip_reset_legal_chk: assert (legal);
        end
    end

endmodule

// File: rtl/cq_queue.sv
module cq_queue #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             accept,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] head,
    output logic             head_valid,
    output logic             full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;
    logic             pop;
    logic             room;

    assign pop        = accept && (cnt_q != '0);
    assign room       = (cnt_q < CNT_W'(DEPTH)) || pop;
    assign base       = cnt_q - CNT_W'(pop);
    assign head       = slot_q[0];
    assign head_valid = (cnt_q != '0);
    assign full       = (cnt_q == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= base + CNT_W'(push && room);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [WIDTH-1:0] shifted;
        if (i == DEPTH - 1) begin : g_last
            assign shifted = '0;
        end else begin : g_mid
            assign shifted = slot_q[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (!flush) begin
                if (push && room && (base == CNT_W'(i))) begin
                    slot_q[i] <= din;
                end else if (pop) begin
                    slot_q[i] <= shifted;
                end
            end
        end
    end

    // R7: the parent never pushes into a queue without room
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> room);

    // R3: an unaccepted head is held unchanged
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (head_valid && !accept && !flush) |=> (head_valid && $stable(head)));

    // R4: the second entry moves to the head on accept
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && (cnt_q > CNT_W'(1)) && !flush) |=>
            (head_valid && (head == $past(slot_q[1]))));

endmodule

// File: rtl/cq_flag.sv
module cq_flag (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic set,
    input  logic ack,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (ack) begin
            flag <= 1'b0;
        end
    end

    // R9: the flag is sticky until acknowledged
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !ack && !clear) |=> flag);

    // R9: a new event beats a simultaneous acknowledge
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set && !clear) |=> flag);

endmodule

// File: rtl/ctrl_cmd_queue.sv
module ctrl_cmd_queue
    import cq_pkg::*;
#(
    parameter int QUEUE_DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode,
    input  logic            wr_en,
    input  logic [7:0]      wr_data,
    input  logic            cmd_accept,
    input  logic            irq_ack,
    output logic            cmd_valid,
    output logic [6:0]      cmd_op,
    output logic            cmd_dma,
    output logic [1:0]      cmd_class,
    output logic            illegal_cmd,
    output logic            chip_reset
);
    cmd_entry_t dec_entry;
    cmd_entry_t head_entry;
    logic       dec_legal;
    logic       dec_rchip;
    logic       q_full;
    logic       take;
    logic       push;
    logic       flush;
    logic       raise;
    logic       chip_reset_q;

    cq_decode u_dec (
        .byte_in       (wr_data),
        .mode          (op_mode_e'(mode)),
        .entry         (dec_entry),
        .legal         (dec_legal),
        .is_chip_reset (dec_rchip)
    );

    assign take  = wr_en && dec_legal && !dec_rchip;
    assign push  = take && (!q_full || (cmd_accept && cmd_valid));
    assign flush = wr_en && dec_rchip;
    assign raise = (wr_en && !dec_legal) || (take && !push);

    cq_queue #(
        .WIDTH (ENTRY_W),
        .DEPTH (QUEUE_DEPTH)
    ) u_q (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .push       (push),
        .accept     (cmd_accept),
        .din        (dec_entry),
        .head       (head_entry),
        .head_valid (cmd_valid),
        .full       (q_full)
    );

    cq_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .clear (flush),
        .set   (raise),
        .ack   (irq_ack),
        .flag  (illegal_cmd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chip_reset_q <= 1'b0;
        end else begin
            chip_reset_q <= flush;
        end
    end

    assign chip_reset = chip_reset_q;
    assign cmd_op     = head_entry.op;
    assign cmd_dma    = head_entry.dma;
    assign cmd_class  = head_entry.cls;

    // R5
    illegal_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dec_legal) |=> illegal_cmd);

    // R7
    drop_full_chk: assert property (@(posedge clk) disable iff (rst)
        (take && q_full && !cmd_accept) |=>
            (illegal_cmd && cmd_valid && $stable(cmd_op)));

    // R8
    chip_reset_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!cmd_valid && !illegal_cmd && chip_reset));

    // R8: pulse is a single cycle
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        (chip_reset && !flush) |=> !chip_reset);

    // R2: the class matches the class bits of the held operation
    class_field_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ((cmd_class == 2'd1) == cmd_op[6]) &&
                      ((cmd_class == 2'd2) == cmd_op[5]) &&
                      ((cmd_class == 2'd3) == cmd_op[4]));

endmodule

// File: tb/tb_ctrl_cmd_queue.sv
module tb_ctrl_cmd_queue;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cmd_accept = 1'b0;
    logic       irq_ack = 1'b0;
    logic       cmd_valid;
    logic [6:0] cmd_op;
    logic       cmd_dma;
    logic [1:0] cmd_class;
    logic       illegal_cmd;
    logic       chip_reset;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ctrl_cmd_queue dut (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .cmd_accept  (cmd_accept),
        .irq_ack     (irq_ack),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_dma     (cmd_dma),
        .cmd_class   (cmd_class),
        .illegal_cmd (illegal_cmd),
        .chip_reset  (chip_reset)
    );

    // {mode[2], byte[8], legal, undefined, class[2]}
    localparam int NV = 18;
    localparam logic [13:0] VEC [NV] = '{
        {2'd0, 8'h41, 1'b1, 1'b0, 2'd1},
        {2'd0, 8'h80, 1'b1, 1'b0, 2'd0},
        {2'd1, 8'hA2, 1'b1, 1'b0, 2'd2},
        {2'd2, 8'h10, 1'b1, 1'b0, 2'd3},
        {2'd2, 8'h9B, 1'b1, 1'b0, 2'd3},
        {2'd1, 8'h2B, 1'b1, 1'b0, 2'd2},
        {2'd1, 8'h84, 1'b1, 1'b0, 2'd0},
        {2'd3, 8'h01, 1'b1, 1'b0, 2'd0},
        {2'd0, 8'h20, 1'b0, 1'b0, 2'd0},
        {2'd1, 8'h12, 1'b0, 1'b0, 2'd0},
        {2'd2, 8'h44, 1'b0, 1'b0, 2'd0},
        {2'd3, 8'h40, 1'b0, 1'b0, 2'd0},
        {2'd0, 8'h05, 1'b0, 1'b1, 2'd0},
        {2'd2, 8'h8F, 1'b0, 1'b1, 2'd0},
        {2'd1, 8'h26, 1'b0, 1'b1, 2'd0},
        {2'd0, 8'h47, 1'b0, 1'b1, 2'd0},
        {2'd2, 8'h13, 1'b0, 1'b1, 2'd0},
        {2'd0, 8'h60, 1'b0, 1'b1, 2'd0}
    };

    task automatic cyc(input logic [1:0] m, input logic we, input logic [7:0] d,
                       input logic acc, input logic ack);
        mode       = m;
        wr_en      = we;
        wr_data    = d;
        cmd_accept = acc;
        irq_ack    = ack;
        @(posedge clk);
        #1;
        wr_en      = 1'b0;
        cmd_accept = 1'b0;
        irq_ack    = 1'b0;
    endtask

    task automatic chk(input string tag, input logic ev, input logic [7:0] eb,
                       input logic [1:0] ec, input logic ei, input logic er);
        logic [12:0] act;
        logic [12:0] exp;
        logic [12:0] msk;
        act = {cmd_valid, cmd_dma, cmd_class, cmd_op, illegal_cmd, chip_reset};
        exp = {ev, eb[7], ec, eb[6:0], ei, er};
        msk = ev ? 13'h1FFF : 13'h1003;
        checks++;
        if ((act & msk) !== (exp & msk)) begin
            failures++;
            $display("FAIL %s act=%h exp=%h (valid,dma,class,op,illegal,reset)",
                     tag, act & msk, exp & msk);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 in reset", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0);
        rst = 1'b0;
        cyc(2'd0, 1'b0, 8'h00, 1'b0, 1'b0);
        chk("R1 after reset", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0);

        // table: decode, mode legality, undefined codes
        for (int k = 0; k < NV; k++) begin
            logic [13:0] v;
            v = VEC[k];
            cyc(v[13:12], 1'b1, v[11:4], 1'b0, 1'b0);
            if (v[3])
                chk("R2 decode", 1'b1, v[11:4], v[1:0], 1'b0, 1'b0);
            else if (v[2])
                chk("R6 undefined", 1'b0, v[11:4], 2'd0, 1'b1, 1'b0);
            else
                chk("R5 mode mismatch", 1'b0, v[11:4], 2'd0, 1'b1, 1'b0);
            cyc(v[13:12], 1'b0, 8'h00, 1'b1, 1'b1);
            chk("R9 ack and R4 accept clear", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0);
        end

        // R4: accept on an empty queue does nothing
        cyc(2'd0, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R4 empty accept", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0);

        // R3 / R4: order of two entries
        cyc(2'd0, 1'b1, 8'h41, 1'b0, 1'b0);
        cyc(2'd0, 1'b1, 8'hC2, 1'b0, 1'b0);
        chk("R3 head kept", 1'b1, 8'h41, 2'd1, 1'b0, 1'b0);
        cyc(2'd0, 1'b0, 8'h00, 1'b0, 1'b0);
        chk("R3 head stable", 1'b1, 8'h41, 2'd1, 1'b0, 1'b0);
        cyc(2'd0, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R4 second advances", 1'b1, 8'hC2, 2'd1, 1'b0, 1'b0);
        cyc(2'd0, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R4 drained", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0);

        // R7: overflow drop
        cyc(2'd2, 1'b1, 8'h10, 1'b0, 1'b0);
        cyc(2'd2, 1'b1, 8'h91, 1'b0, 1'b0);
        cyc(2'd2, 1'b1, 8'h12, 1'b0, 1'b0);
        chk("R7 overflow flagged", 1'b1, 8'h10, 2'd3, 1'b1, 1'b0);
        cyc(2'd2, 1'b0, 8'h00, 1'b1, 1'b1);
        chk("R7 second kept", 1'b1, 8'h91, 2'd3, 1'b0, 1'b0);
        cyc(2'd2, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R7 third was dropped", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0);

        // R7: write while full with a simultaneous accept
        cyc(2'd1, 1'b1, 8'h20, 1'b0, 1'b0);
        cyc(2'd1, 1'b1, 8'h21, 1'b0, 1'b0);
        cyc(2'd1, 1'b1, 8'hA5, 1'b1, 1'b0);
        chk("R7 accept+write head", 1'b1, 8'h21, 2'd2, 1'b0, 1'b0);
        cyc(2'd1, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R7 accept+write queued", 1'b1, 8'hA5, 2'd2, 1'b0, 1'b0);
        cyc(2'd1, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R7 accept+write drained", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0);

        // R8: reset chip clears queue and flag, beats accept
        cyc(2'd2, 1'b1, 8'h18, 1'b0, 1'b0);
        cyc(2'd2, 1'b1, 8'h1A, 1'b0, 1'b0);
        cyc(2'd2, 1'b1, 8'h41, 1'b0, 1'b0);
        chk("R5 flag before reset", 1'b1, 8'h18, 2'd3, 1'b1, 1'b0);
        cyc(2'd2, 1'b1, 8'h82, 1'b1, 1'b0);
        chk("R8 reset chip", 1'b0, 8'h00, 2'd0, 1'b0, 1'b1);
        cyc(2'd2, 1'b0, 8'h00, 1'b0, 1'b0);
        chk("R8 pulse ends", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0);
        cyc(2'd3, 1'b1, 8'h02, 1'b0, 1'b0);
        chk("R8 idle mode reset", 1'b0, 8'h00, 2'd0, 1'b0, 1'b1);

        // R9: set beats ack, sticky, then ack clears
        cyc(2'd0, 1'b1, 8'h30, 1'b0, 1'b0);
        chk("R6 multi-class", 1'b0, 8'h00, 2'd0, 1'b1, 1'b0);
        cyc(2'd0, 1'b1, 8'h10, 1'b0, 1'b1);
        chk("R9 set over ack", 1'b0, 8'h00, 2'd0, 1'b1, 1'b0);
        cyc(2'd0, 1'b0, 8'h00, 1'b0, 1'b0);
        chk("R9 sticky", 1'b0, 8'h00, 2'd0, 1'b1, 1'b0);
        cyc(2'd0, 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R9 ack clears", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0);

        // R1: reset with content pending
        cyc(2'd0, 1'b1, 8'h44, 1'b0, 1'b0);
        cyc(2'd0, 1'b1, 8'h99, 1'b0, 1'b0);
        rst = 1'b1;
        cyc(2'd0, 1'b0, 8'h00, 1'b0, 1'b0);
        rst = 1'b0;
        chk("R1 mid-run reset", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule